// File: doc/BRIEF.md
# Width-Configurable Single-Port Block RAM

This block is a synchronous single-port memory whose physical storage is a fixed array of 4 rows of 8 bits. A static aspect setting lets that one array be used as 4 words of 8 bits, 8 words of 4 bits, 16 words of 2 bits or 32 words of 1 bit. The two upper address bits always pick a row. The three lower address bits pick a column slice of that row. In each mode, only as many of those lower bits are used as the slice count needs.

Address, write data, write enable and the aspect setting are all captured in input registers first. A configuration decoder then turns the active slice bits into a column-select mask. Each select line carries either its address bit or a constant one, depending on the aspect. The mask gates the per-bit write enables. The output multiplexer uses the same slice position to extract the read slice. The result is right-justified and zero-extended to 8 bits.

The aspect setting is meant to be changed only between uses of the memory. Changing it needs no extra data or address pins beyond the widest word and the deepest address.

Top module: `cfgw_ram`

## Requirements
- R1: While `rst_n` is low, `rdata` is 0.
- R2: The read data for the inputs presented before clock edge N appears on `rdata` after edge N+1 and is held until the next edge.
- R3: With `cfg_mode` = 0 (4 words of 8 bits), `addr[4:3]` selects the row, the whole row is read or written, and `addr[2:0]` has no effect.
- R4: With `cfg_mode` = 1 (8 words of 4 bits), `addr[2]` selects slice k and the slice occupies row bits [4k+3:4k]. `addr[1:0]` has no effect.
- R5: With `cfg_mode` = 2 (16 words of 2 bits), `addr[2:1]` selects slice k, which occupies row bits [2k+1:2k]. `addr[0]` has no effect.
- R6: With `cfg_mode` = 3 (32 words of 1 bit), `addr[2:0]` selects the single row bit k.
- R7: A narrow write changes only the bits of the addressed slice. All other bits of that row, and all other rows, keep their contents.
- R8: A write of width w stores `wdata[w-1:0]`. The upper bits of `wdata` are ignored.
- R9: In a mode of width w, `rdata[7:w]` is 0.
- R10: A write cycle returns on `rdata` the contents the addressed slice had before that write.
- R11: All modes share one flat storage, in which bit b of row r is element 8r+b. Data written in one mode is read back in another mode through that mapping.
- R12: A cycle with `wr_en` low changes no stored bit, whatever `wdata` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| cfg_mode | input | 2 | Aspect setting: 0 = 8-bit, 1 = 4-bit, 2 = 2-bit, 3 = 1-bit words |
| addr | input | 5 | Word address; [4:3] row, [2:0] slice select as far as the mode uses it |
| wdata | input | 8 | Write data; the low w bits are used |
| wr_en | input | 1 | Write enable for the current access |
| rdata | output | 8 | Read slice, right-justified, upper bits zero |

## Verification
The bench writes data in one mode and reads it back in the others. It sweeps every address in every mode, including the address bits each mode must ignore. A decoder that looked at an ignored bit would return the neighbouring slice. A write mask that reached past the slice would corrupt the adjacent bits of the row, which the following full-width reads expose. Writes with junk in the upper data bits catch a design that stores the wrong lane. Same-address write-and-read cycles catch a design that forwards the new data instead of returning the old contents. A long random run compares every read against a flat 32-bit model.

// File: rtl/cfgw_ram_pkg.sv
package cfgw_ram_pkg;

    typedef enum logic [1:0] {
        ASP_W8 = 2'd0,
        ASP_W4 = 2'd1,
        ASP_W2 = 2'd2,
        ASP_W1 = 2'd3
    } aspect_e;

    // Number of data bits in one word for a given aspect code.
    function automatic int slice_width(input int data_w, input int mode);
        return data_w >> mode;
    endfunction

endpackage

// File: rtl/cfgw_ram_dec.sv
// Width-configuration decoder: each select line is either its address
// bit (true/complement pair) or forced high, then every column ANDs the
// lines that match its own index.
module cfgw_ram_dec #(
    parameter  int DATA_W = 8,
    localparam int SEL_W  = $clog2(DATA_W),
    localparam int MODE_W = $clog2(SEL_W + 1)
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] col_sel
);

    logic [SEL_W-1:0] line_t;
    logic [SEL_W-1:0] line_c;

    always_comb begin
        for (int p = 0; p < SEL_W; p++) begin
            if (p >= SEL_W - int'(mode)) begin
                line_t[p] = sel[p];
                line_c[p] = ~sel[p];
            end else begin
                line_t[p] = 1'b1;
                line_c[p] = 1'b1;
            end
        end
    end

    for (genvar c = 0; c < DATA_W; c++) begin : g_col
        localparam logic [SEL_W-1:0] CIDX = SEL_W'(c);
        logic hit;
        always_comb begin
            hit = 1'b1;
            for (int p = 0; p < SEL_W; p++) begin
                hit = hit & (CIDX[p] ? line_t[p] : line_c[p]);
            end
        end
        assign col_sel[c] = hit;
    end

endmodule

// File: rtl/cfgw_ram_wrgen.sv
// Per-bit write enables and lane replication of narrow write data.
module cfgw_ram_wrgen #(
    parameter  int DATA_W = 8,
    localparam int SEL_W  = $clog2(DATA_W),
    localparam int MODE_W = $clog2(SEL_W + 1)
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] col_sel,
    output logic [DATA_W-1:0] bit_we,
    output logic [DATA_W-1:0] row_wdata
);
    import cfgw_ram_pkg::*;

    int lane_mask;

    always_comb begin
        lane_mask = slice_width(DATA_W, int'(mode)) - 1;
        for (int c = 0; c < DATA_W; c++) begin
            row_wdata[c] = wdata[SEL_W'(c & lane_mask)];
        end
        bit_we = wr_en ? col_sel : '0;
    end

endmodule

// File: rtl/cfgw_ram_array.sv
// Physical storage: ROWS x DATA_W cells, bit-granular write, registered
// full-row read that returns pre-write contents.
module cfgw_ram_array #(
    parameter  int DATA_W = 8,
    parameter  int ROWS   = 4,
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] bit_we,
    input  logic [DATA_W-1:0] row_wdata,
    output logic [DATA_W-1:0] rd_row
);

    logic [DATA_W-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        for (int c = 0; c < DATA_W; c++) begin
            if (bit_we[c]) begin
                cells[row][c] <= row_wdata[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_row <= '0;
        end else begin
            rd_row <= cells[row];
        end
    end

endmodule

// File: rtl/cfgw_ram_rdmux.sv
// Output slice multiplexer: right-justify the addressed slice, zero above.
module cfgw_ram_rdmux #(
    parameter  int DATA_W = 8,
    localparam int SEL_W  = $clog2(DATA_W),
    localparam int MODE_W = $clog2(SEL_W + 1)
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] row_data,
    output logic [DATA_W-1:0] rdata
);
    import cfgw_ram_pkg::*;

    int width;
    int keep_low;
    int offset;

    always_comb begin
        width    = slice_width(DATA_W, int'(mode));
        keep_low = SEL_W - int'(mode);
        offset   = int'(sel) & ~((1 << keep_low) - 1);
        for (int j = 0; j < DATA_W; j++) begin
            if (j < width) begin
                rdata[j] = row_data[SEL_W'((offset + j) & (DATA_W - 1))];
            end else begin
                rdata[j] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfgw_ram.sv
module cfgw_ram #(
    parameter  int DATA_W = 8,
    parameter  int ROWS   = 4,
    localparam int SEL_W  = $clog2(DATA_W),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = ROW_W + SEL_W,
    localparam int MODE_W = $clog2(SEL_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata
);

    // Input capture stage.
    logic [MODE_W-1:0] mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;

    // Read-side alignment stage.
    logic [MODE_W-1:0] mode_rd;
    logic [SEL_W-1:0]  sel_rd;

    logic [DATA_W-1:0] col_sel;
    logic [DATA_W-1:0] bit_we;
    logic [DATA_W-1:0] row_wdata;
    logic [DATA_W-1:0] rd_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else begin
            mode_q  <= cfg_mode;
            addr_q  <= addr;
            wdata_q <= wdata;
            we_q    <= wr_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_rd <= '0;
            sel_rd  <= '0;
        end else begin
            mode_rd <= mode_q;
            sel_rd  <= addr_q[SEL_W-1:0];
        end
    end

    cfgw_ram_dec #(.DATA_W(DATA_W)) u_dec (
        .mode    (mode_q),
        .sel     (addr_q[SEL_W-1:0]),
        .col_sel (col_sel)
    );

    cfgw_ram_wrgen #(.DATA_W(DATA_W)) u_wrgen (
        .mode      (mode_q),
        .wr_en     (we_q),
        .wdata     (wdata_q),
        .col_sel   (col_sel),
        .bit_we    (bit_we),
        .row_wdata (row_wdata)
    );

    cfgw_ram_array #(.DATA_W(DATA_W), .ROWS(ROWS)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .row       (addr_q[ADDR_W-1:SEL_W]),
        .bit_we    (bit_we),
        .row_wdata (row_wdata),
        .rd_row    (rd_row)
    );

    cfgw_ram_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .mode     (mode_rd),
        .sel      (sel_rd),
        .row_data (rd_row),
        .rdata    (rdata)
    );

endmodule

// File: rtl/cfgw_ram_chk.sv
module cfgw_ram_chk #(
    parameter  int DATA_W = 8,
    parameter  int ROWS   = 4,
    localparam int SEL_W  = $clog2(DATA_W),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = ROW_W + SEL_W,
    localparam int MODE_W = $clog2(SEL_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] cfg_mode,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata
);

    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    function automatic logic [DATA_W-1:0] lane_bits(input logic [MODE_W-1:0] m);
        logic [DATA_W-1:0] r;
        for (int j = 0; j < DATA_W; j++) begin
            r[j] = (j < (DATA_W >> m));
        end
        return r;
    endfunction

    // R9: bits above the slice width are zero.
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2) |-> ((rdata & ~lane_bits($past(cfg_mode, 2))) == '0));

    // R8: a write followed by a read of the same word returns the low lane of the written data.
    a_r8_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && $past(wr_en, 3)
         && ($past(addr, 3) == $past(addr, 2))
         && ($past(cfg_mode, 3) == $past(cfg_mode, 2)))
        |-> (rdata == ($past(wdata, 3) & lane_bits($past(cfg_mode, 3)))));

    // R10: a write cycle still reads the old contents.
    a_r10_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && $past(wr_en, 2) && !$past(wr_en, 3)
         && ($past(addr, 3) == $past(addr, 2))
         && ($past(cfg_mode, 3) == $past(cfg_mode, 2)))
        |-> $stable(rdata));

    // R12: repeated reads with write enable low see unchanged data.
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && !$past(wr_en, 2) && !$past(wr_en, 3)
         && ($past(addr, 3) == $past(addr, 2))
         && ($past(cfg_mode, 3) == $past(cfg_mode, 2)))
        |-> $stable(rdata));

endmodule

bind cfgw_ram cfgw_ram_chk #(.DATA_W(DATA_W), .ROWS(ROWS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rdata    (rdata)
);

// File: tb/test_cfgw_ram.sv
module test_cfgw_ram;
    import cfgw_ram_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [4:0] addr = 5'd0;
    logic [7:0] wdata = 8'd0;
    logic       wr_en = 1'b0;
    logic [7:0] rdata;

    always #2 clk = ~clk;

    cfgw_ram i_cfgw_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rdata    (rdata)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
        int         due;
        bit         chk;
    } item_t;

    item_t      sbq[$];
    logic [31:0] flat_ref;
    int         cyc = 0;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Flat model: element 8*row + bit; slice k of width w starts at k*w.
    function automatic logic [7:0] model_read(input int m, input logic [4:0] a);
        int w = 8 >> m;
        int k = int'(a[2:0]) >> (3 - m);
        int base = int'(a[4:3]) * 8 + k * w;
        logic [7:0] r = '0;
        for (int j = 0; j < w; j++) r[j] = flat_ref[base + j];
        return r;
    endfunction

    task automatic model_write(input int m, input logic [4:0] a, input logic [7:0] d);
        int w = 8 >> m;
        int k = int'(a[2:0]) >> (3 - m);
        int base = int'(a[4:3]) * 8 + k * w;
        for (int j = 0; j < w; j++) flat_ref[base + j] = d[j];
    endtask

    // Driver: one access per clock, expected result queued with its due cycle.
    task automatic access(input logic [1:0] m, input logic [4:0] a, input logic [7:0] d,
                          input bit we, input string tag, input bit chk);
        item_t it;
        @(posedge clk);
        #1;
        cfg_mode = m;
        addr     = a;
        wdata    = d;
        wr_en    = we;
        it.exp = model_read(int'(m), a);
        it.tag = tag;
        it.due = cyc + 2;
        it.chk = chk;
        sbq.push_back(it);
        if (we) model_write(int'(m), a, d);
    endtask

    task automatic rd(input logic [1:0] m, input logic [4:0] a, input string tag);
        access(m, a, 8'($urandom), 1'b0, tag, 1'b1);
    endtask

    // Monitor: compare results away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                item_t it;
                it = sbq.pop_front();
                if (it.chk) begin
                    total++;
                    if (it.due != cyc || rdata !== it.exp) begin
                        bad++;
                        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    string mtag [4] = '{"R3", "R4", "R5", "R6"};

    initial begin
        flat_ref = 'x;
        // R1: reset state
        repeat (2) begin
            @(negedge clk);
            total++;
            if (rdata !== 8'h00) begin
                bad++;
                $display("FAIL R1: rdata=%h expected=00", rdata);
            end
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // Fill the array in wide mode.
        for (int r = 0; r < 4; r++)
            access(ASP_W8, {2'(r), 3'b000}, 8'h3C ^ 8'(r * 8'h51), 1'b1, "fill", 1'b0);

        // R2: read right after the last write
        rd(ASP_W8, 5'b11_000, "R2");
        // R3..R6: full sweeps including ignored address bits (R9 on narrow modes)
        for (int a = 0; a < 32; a++) rd(ASP_W8, 5'(a), "R3");
        for (int a = 0; a < 32; a++) rd(ASP_W4, 5'(a), "R4");
        for (int a = 0; a < 32; a++) rd(ASP_W2, 5'(a), "R5");
        for (int a = 0; a < 32; a++) rd(ASP_W1, 5'(a), "R6_R9");

        // R7: narrow write keeps the rest of the row
        access(ASP_W4, 5'b01_100, 8'hA5, 1'b1, "R10", 1'b1);
        rd(ASP_W8, 5'b01_000, "R7");
        rd(ASP_W8, 5'b00_000, "R7");
        // R8: upper write data bits ignored
        access(ASP_W1, 5'b10_011, 8'hFE, 1'b1, "R10", 1'b1);
        rd(ASP_W8, 5'b10_000, "R8");
        access(ASP_W2, 5'b10_110, 8'hF1, 1'b1, "R10", 1'b1);
        rd(ASP_W2, 5'b10_110, "R8");
        rd(ASP_W8, 5'b10_000, "R8");

        // R10: write then same-address read
        access(ASP_W2, 5'b11_010, 8'h03, 1'b1, "R10", 1'b1);
        rd(ASP_W2, 5'b11_010, "R10");
        access(ASP_W8, 5'b11_000, 8'h5A, 1'b1, "R10", 1'b1);
        access(ASP_W8, 5'b11_000, 8'hC3, 1'b1, "R10", 1'b1);
        rd(ASP_W8, 5'b11_000, "R10");

        // R12: write enable low changes nothing
        access(ASP_W8, 5'b01_000, 8'hFF, 1'b0, "R12", 1'b1);
        access(ASP_W1, 5'b01_101, 8'hFF, 1'b0, "R12", 1'b1);
        rd(ASP_W8, 5'b01_000, "R12");

        // R11: bit writes reinterpreted as words
        for (int b = 0; b < 8; b++)
            access(ASP_W1, {2'b11, 3'(b)}, 8'(8'h96 >> b), 1'b1, "R11", 1'b1);
        rd(ASP_W8, 5'b11_000, "R11");
        rd(ASP_W4, 5'b11_100, "R11");
        rd(ASP_W2, 5'b11_010, "R11");

        // Random accesses in every mode against the flat model.
        for (int m = 0; m < 4; m++) begin
            repeat (250)
                access(2'(m), 5'($urandom), 8'($urandom), 1'($urandom), mtag[m], 1'b1);
        end

        repeat (6) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule